// File: doc/BRIEF.md
# Serial Peripheral Port Controller with Mode-Fault Protection

This block is a byte-wide serial peripheral port that can run as the clock-generating master or as a slave clocked from outside. Software reaches it through a small register bus with four addresses: control, clock divide, status and data. In master mode, a write to the data address starts an eight-bit exchange. The shift clock is made by dividing the system clock. Its rest level, the edge on which each bit is sampled and the bit order are all chosen in the control register. In slave mode, the block shifts on the external clock, but only while its select input is held low.

The block guards against a second master on the same wires. If the block is in master mode with its select pin configured as an input, and that input goes low, the block records a mode fault. It then drops out of master mode, disables itself and abandons any exchange in progress. It stays locked out until software runs a recovery sequence. Pin drive is reported as value/output-enable pairs. An open-drain option turns every output, including spare general-purpose outputs on the same port, into drive-low/release-high. The register bus has no back-pressure. Accesses complete in one cycle, and a data write that arrives while a master exchange is running is dropped.

Top module: `spi_mf_ctrl`

## Requirements
- R1: Register map. Address 0 is control: bit0 enable, bit1 master, bit2 clock polarity, bit3 clock phase, bit4 LSB-first, bit5 select-output enable, bit6 open-drain, bit7 interrupt enable. Address 1 is the clock divide. Address 2 is status: bit7 transfer done, bit6 mode fault. Address 3 is data: a write loads the transmit byte, and a read returns the received byte. All registers read zero after reset.
- R2: `irq` is high exactly when interrupt enable is 1 and at least one of the transfer-done flag and the mode-fault flag is set.
- R3: With enable at 0, no SPI pin has its output enable set, the shift state is held cleared, and a data write starts no exchange.
- R4: In master mode with `ss_dir` at 0, a low on `ss_i` sets the mode-fault flag. It also clears the master and enable bits and stops any exchange, after which the clock is no longer driven.
- R5: While the mode-fault flag is set, enable reads 0 and control writes cannot set it. A status read taken while the flag is set, followed by a control write, clears the flag. That recovery write still leaves enable at 0, and a later control write may set it.
- R6: When no exchange is running, `sck_o` equals the clock-polarity bit.
- R7: With phase 0, data is sampled on the first (leading) clock edge of each bit and changes on the second. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: With LSB-first at 0, bit 7 goes out and comes in first. With LSB-first at 1, bit 0 is first. The received byte reads back in its natural bit positions.
- R9: The transfer-done flag sets after the eighth bit. It clears only when a status read that saw it set is followed by a data-register access. A data access with no such status read first leaves it set.
- R10: `ss_oe` is 1 only in master mode with enable, select-output enable and `ss_dir` all at 1. `ss_o` is low while a master exchange runs and high otherwise.
- R11: With open-drain at 1, every SPI output and every general-purpose output enables its driver only when its value is 0. With open-drain at 0, each output drives whenever it is active. A general-purpose output is active when its `gp_dir` bit is 1.
- R12: In master mode, each clock half-period lasts divide+2 system clocks, and an exchange has exactly 16 clock edges.
- R13: In slave mode, clock edges on `sck_i` while `ss_i` is high are ignored. With `ss_i` low, a full frame is exchanged and the done flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | External shift clock (slave) |
| sck_o | output | 1 | Shift clock value (master) |
| sck_oe | output | 1 | Shift clock driver enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out value (master) |
| mosi_oe | output | 1 | Master data-out driver enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out value (slave) |
| miso_oe | output | 1 | Slave data-out driver enable |
| ss_i | input | 1 | Select pin input level |
| ss_dir | input | 1 | Select pin direction, 1 = output |
| ss_o | output | 1 | Select pin output value |
| ss_oe | output | 1 | Select pin driver enable |
| gp_val | input | 2 | Spare port output values |
| gp_dir | input | 2 | Spare port directions, 1 = output |
| gp_oe | output | 2 | Spare port driver enables |

## Verification
The hardest state to reach is a mode fault that lands in the middle of a running master exchange, followed by a recovery in which each step is checked on its own. The stimulus picks a long clock divide and starts a frame. Partway through the frame, it pulls the select input low while the select pin is configured as an input. It then tries to re-enable the block with no status read first, and expects that attempt to have no effect. Only after that does it read status, release the select line and issue the recovery write. It then checks that enable stays off after the recovery write and comes back on the write after that.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DIV  = 2'd1,
    A_STAT = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic ie;
    logic od;
    logic ssoe;
    logic lsb;
    logic cpha;
    logic cpol;
    logic master;
    logic en;
  } ctrl_t;

  // driver enable of one pin, honouring the open-drain option
  function automatic logic pad_oe(input logic drive, input logic val, input logic od);
    return drive & (~od | ~val);
  endfunction

endpackage

// File: rtl/spi_mf_sckgen.sv
module spi_mf_sckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             ph,
  output logic             lead,
  output logic             trail
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = {1'b0, div} + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ph <= 1'b0; lead <= 1'b0; trail <= 1'b0;
    end else if (!run) begin
      cnt <= '0; ph <= 1'b0; lead <= 1'b0; trail <= 1'b0;
    end else begin
      lead  <= 1'b0;
      trail <= 1'b0;
      if (cnt == limit) begin
        cnt   <= '0;
        ph    <= ~ph;
        lead  <= ~ph;
        trail <= ph;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R6: the clock phase returns to rest once the generator stops
  a_r6_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ph && !lead && !trail));

endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          off,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          lead,
  input  logic          trail,
  input  logic          sin,
  output logic          sout,
  output logic [DW-1:0] rx_word,
  output logic          frame_done
);
  localparam int CW = $clog2(2 * DW);
  localparam logic [CW-1:0] LAST = CW'(2 * DW - 1);

  logic [CW-1:0] ecnt;
  logic [DW-1:0] tx;
  logic edge_ev, samp, shft;

  assign edge_ev    = lead | trail;
  assign samp       = cpha ? trail : lead;
  assign shft       = (cpha ? lead : trail) && !(cpha && ecnt == '0);
  assign frame_done = edge_ev && (ecnt == LAST) && !clr && !off;
  assign sout       = lsb_first ? tx[0] : tx[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0; tx <= '0; rx_word <= '0;
    end else if (off) begin
      ecnt <= '0; tx <= '0; rx_word <= '0;
    end else begin
      if (clr)          ecnt <= '0;
      else if (edge_ev) ecnt <= (ecnt == LAST) ? '0 : ecnt + CW'(1);

      if (load)
        tx <= load_word;
      else if (!clr && shft)
        tx <= lsb_first ? (tx >> 1) : (tx << 1);

      if (!clr && samp)
        rx_word <= lsb_first ? {sin, rx_word[DW-1:1]} : {rx_word[DW-2:0], sin};
    end
  end

  // R3: disabled state leaves counter and transmit byte cleared
  a_r3_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (ecnt == '0 && tx == '0));

  // R9: the frame ends on the last edge and the count starts over
  a_r9_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (ecnt == '0));

endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GP_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            irq,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            mosi_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  input  logic            miso_i,
  output logic            miso_o,
  output logic            miso_oe,
  input  logic            ss_i,
  input  logic            ss_dir,
  output logic            ss_o,
  output logic            ss_oe,
  input  logic [GP_W-1:0] gp_val,
  input  logic [GP_W-1:0] gp_dir,
  output logic [GP_W-1:0] gp_oe
);
  localparam int FRAME_W = 8;

  ctrl_t ctrl;
  logic [DIV_W-1:0] div_q;
  logic spif, modf, arm_f, arm_m, busy;
  logic ss_m, ss_s, sck_m, sck_s, sck_d;

  logic ctrl_wr, div_wr, stat_rd, data_wr, data_acc;
  logic fault_det, start, slave_sel, drive_m;
  logic m_ph, m_lead, m_trail, s_lead, s_trail, sck_ch;
  logic eng_sout, frame_done;
  logic [FRAME_W-1:0] rx_word;

  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign div_wr   = wr_en && (addr == A_DIV);
  assign stat_rd  = rd_en && (addr == A_STAT);
  assign data_wr  = wr_en && (addr == A_DATA);
  assign data_acc = (wr_en || rd_en) && (addr == A_DATA);

  assign fault_det = ctrl.en && ctrl.master && !ss_dir && !ss_s;
  assign start     = data_wr && ctrl.en && ctrl.master && !busy && !fault_det;
  assign slave_sel = ctrl.en && !ctrl.master && !ss_s;
  assign drive_m   = ctrl.en && ctrl.master;

  // input synchronisers for the external select and clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_m <= 1'b1; ss_s <= 1'b1; sck_m <= 1'b0; sck_s <= 1'b0; sck_d <= 1'b0;
    end else begin
      ss_m <= ss_i; ss_s <= ss_m; sck_m <= sck_i; sck_s <= sck_m; sck_d <= sck_s;
    end
  end

  assign sck_ch  = sck_s ^ sck_d;
  assign s_lead  = sck_ch && (sck_s != ctrl.cpol);
  assign s_trail = sck_ch && (sck_s == ctrl.cpol);

  // control register with fault lock-out and recovery
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; modf <= 1'b0; arm_m <= 1'b0;
    end else if (fault_det) begin
      ctrl.en <= 1'b0; ctrl.master <= 1'b0; modf <= 1'b1; arm_m <= 1'b0;
    end else begin
      if (stat_rd) arm_m <= modf;
      if (ctrl_wr) begin
        ctrl  <= ctrl_t'(wdata);
        arm_m <= 1'b0;
        if (modf) begin
          ctrl.en <= 1'b0;
          if (arm_m) modf <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_wr) div_q <= wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; spif <= 1'b0; arm_f <= 1'b0;
    end else begin
      if (fault_det || !ctrl.en || frame_done) busy <= 1'b0;
      else if (start)                          busy <= 1'b1;

      if (frame_done)             spif <= 1'b1;
      else if (data_acc && arm_f) spif <= 1'b0;

      if (data_acc)     arm_f <= 1'b0;
      else if (stat_rd) arm_f <= spif;
    end
  end

  spi_mf_sckgen #(.DIV_W(DIV_W)) u_sckgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .div   (div_q),
    .ph    (m_ph),
    .lead  (m_lead),
    .trail (m_trail)
  );

  spi_mf_shifter #(.DW(FRAME_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .off        (!ctrl.en),
    .clr        (ctrl.master ? !busy : !slave_sel),
    .load       (start || (data_wr && ctrl.en && !ctrl.master)),
    .load_word  (wdata),
    .cpha       (ctrl.cpha),
    .lsb_first  (ctrl.lsb),
    .lead       (ctrl.master ? m_lead  : s_lead),
    .trail      (ctrl.master ? m_trail : s_trail),
    .sin        (ctrl.master ? miso_i  : mosi_i),
    .sout       (eng_sout),
    .rx_word    (rx_word),
    .frame_done (frame_done)
  );

  // pin values and driver enables
  assign sck_o   = ctrl.cpol ^ m_ph;
  assign mosi_o  = eng_sout;
  assign miso_o  = eng_sout;
  assign ss_o    = ~busy;
  assign sck_oe  = pad_oe(drive_m, sck_o, ctrl.od);
  assign mosi_oe = pad_oe(drive_m, mosi_o, ctrl.od);
  assign miso_oe = pad_oe(slave_sel, miso_o, ctrl.od);
  assign ss_oe   = pad_oe(drive_m && ctrl.ssoe && ss_dir, ss_o, ctrl.od);

  for (genvar g = 0; g < GP_W; g++) begin : g_gp
    assign gp_oe[g] = pad_oe(gp_dir[g], gp_val[g], ctrl.od);
  end

  assign irq = ctrl.ie && (spif || modf);

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata = ctrl;
      A_DIV:  rdata[DIV_W-1:0] = div_q;
      A_STAT: rdata = {spif, modf, 6'b0};
      A_DATA: rdata = rx_word;
    endcase
  end

  // R4: a recorded fault has already left master mode and stopped the exchange
  a_r4_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> (!ctrl.en && !ctrl.master && !busy));

  // R5: enable stays off as long as the fault flag is up
  a_r5_en_masked: assert property (@(posedge clk) disable iff (!rst_n)
    modf |-> !ctrl.en);

  // R9: the end of a frame raises the done flag
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> spif);

endmodule

// File: tb/spi_mf_ctrl_bench.sv
module spi_mf_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq;
  logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1, ss_dir = 1'b1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
  logic [1:0] gp_val = 2'b00, gp_dir = 2'b00, gp_oe;

  int total = 0, bad = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_mf_ctrl u_spi_mf_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_i(ss_i), .ss_dir(ss_dir), .ss_o(ss_o), .ss_oe(ss_oe),
    .gp_val(gp_val), .gp_dir(gp_dir), .gp_oe(gp_oe)
  );

  // vector: [31] cpol [30] cpha [29] lsb [23:16] div [15:8] tx byte [7:0] slave byte
  localparam logic [31:0] VEC [5] = '{
    {3'b000, 5'd0, 8'd0, 8'hA5, 8'h3C},
    {3'b100, 5'd0, 8'd1, 8'h96, 8'hC3},
    {3'b011, 5'd0, 8'd2, 8'h81, 8'h7E},
    {3'b111, 5'd0, 8'd0, 8'h5A, 8'h01},
    {3'b010, 5'd0, 8'd3, 8'hF0, 8'h80}
  };

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // slave model watching the master clock
  bit mon_on = 0;
  logic sck_prev, m_cpol, m_cpha;
  logic [7:0] pat, got;
  int n_edges, n_lead, n_trail, n_samp, t_first, gap, ss_bad;

  always @(negedge clk) begin
    if (mon_on && sck_o !== sck_prev) begin
      automatic bit is_lead = (sck_o != m_cpol);
      automatic int idx;
      sck_prev = sck_o;
      n_edges++;
      if (n_edges == 1) t_first = cyc;
      else if (n_edges == 2) gap = cyc - t_first;
      if (ss_oe !== 1'b1 || ss_o !== 1'b0) ss_bad++;
      if (is_lead != m_cpha) begin
        got[n_samp % 8] = mosi_o;
        n_samp++;
      end
      if (is_lead) n_lead++; else n_trail++;
      if (m_cpha) idx = (n_lead == 0) ? 0 : (n_lead - 1) % 8;
      else        idx = n_trail % 8;
      miso_i = pat[idx];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset values
    rd(2'd0, d); chk(d == 8'h00, "R1 ctrl reset", d, 8'h00);
    rd(2'd2, d); chk(d == 8'h00, "R1 status reset", d, 8'h00);
    chk(irq == 1'b0, "R2 irq at reset", irq, 0);
    // R3: disabled block drives nothing and a data write starts nothing
    wr(2'd3, 8'h55);
    idle(40);
    chk({sck_oe, mosi_oe, miso_oe, ss_oe} == 4'b0000, "R3 pins quiet when off",
        {sck_oe, mosi_oe, miso_oe, ss_oe}, 0);
    rd(2'd2, d); chk(d[7] == 1'b0, "R3 no frame when off", d[7], 0);

    // master table: ie | ssoe | lsb | cpha | cpol | master | en
    for (int v = 0; v < 5; v++) begin
      automatic logic cp = VEC[v][31], ch = VEC[v][30], lf = VEC[v][29];
      automatic logic [7:0] dv = VEC[v][23:16], tx = VEC[v][15:8], sb = VEC[v][7:0];
      automatic bit seen = 0;
      wr(2'd0, 8'h00);
      ss_dir = 1'b1; ss_i = 1'b1;
      wr(2'd1, dv);
      wr(2'd0, {1'b1, 1'b0, 1'b1, lf, ch, cp, 1'b1, 1'b1});
      idle(3);
      chk(sck_o == cp, "R6 rest level before frame", sck_o, cp);
      chk(ss_o == 1'b1 && ss_oe == 1'b1, "R10 select high when idle", {ss_o, ss_oe}, 2'b11);
      m_cpol = cp; m_cpha = ch;
      pat = lf ? sb : rev8(sb);
      miso_i = pat[0];
      n_edges = 0; n_lead = 0; n_trail = 0; n_samp = 0; gap = 0; ss_bad = 0; got = 8'h00;
      sck_prev = sck_o;
      mon_on = 1;
      wr(2'd3, tx);
      for (int k = 0; k < 3000 && !seen; k++) begin
        @(negedge clk);
        if (irq) seen = 1;
      end
      idle(4);
      mon_on = 0;
      chk(seen, "R2 irq on frame end", seen, 1);
      chk(n_edges == 16, "R12 edge count", n_edges, 16);
      chk(gap == dv + 2, "R12 half period", gap, dv + 2);
      chk(got == (lf ? tx : rev8(tx)), "R7 R8 bits sent in order", got, lf ? tx : rev8(tx));
      chk(ss_bad == 0, "R10 select low during frame", ss_bad, 0);
      chk(sck_o == cp, "R6 rest level after frame", sck_o, cp);
      rd(2'd2, d); chk(d[7] == 1'b1, "R9 done flag", d, 8'h80);
      rd(2'd3, d); chk(d == sb, "R8 received byte", d, sb);
      idle(1);
      chk(irq == 1'b0, "R2 irq drops after clear", irq, 0);
    end

    // R10: select output conditions
    wr(2'd0, 8'h00);
    ss_i = 1'b1; ss_dir = 1'b0;
    wr(2'd0, 8'h23);
    idle(2);
    chk(ss_oe == 1'b0, "R10 no drive when pin is input", ss_oe, 0);
    ss_dir = 1'b1;
    wr(2'd0, 8'h03);
    idle(2);
    chk(ss_oe == 1'b0, "R10 no drive without enable bit", ss_oe, 0);
    wr(2'd0, 8'h21);
    idle(2);
    chk(ss_oe == 1'b0, "R10 no drive in slave mode", ss_oe, 0);

    // R11: open-drain pattern; tx reset to 0 so data out is 0, select out is 1
    wr(2'd0, 8'h00);
    gp_val = 2'b10; gp_dir = 2'b11;
    wr(2'd0, 8'h63);
    idle(2);
    chk({sck_oe, mosi_oe, ss_oe, gp_oe} == 5'b11001, "R11 open-drain cpol0",
        {sck_oe, mosi_oe, ss_oe, gp_oe}, 5'b11001);
    wr(2'd0, 8'h67);
    idle(2);
    chk(sck_oe == 1'b0, "R11 open-drain releases high clock", sck_oe, 0);
    wr(2'd0, 8'h27);
    idle(2);
    chk({sck_oe, ss_oe, gp_oe} == 4'b1111, "R11 push-pull drives all",
        {sck_oe, ss_oe, gp_oe}, 4'b1111);
    gp_dir = 2'b01;
    idle(1);
    chk(gp_oe == 2'b01, "R11 input gp pin not driven", gp_oe, 2'b01);

    // R4 R5: fault in the middle of a frame, then recovery
    wr(2'd0, 8'h00);
    ss_i = 1'b1; ss_dir = 1'b0;
    wr(2'd1, 8'd20);
    wr(2'd0, 8'h83);
    wr(2'd3, 8'hC3);
    idle(60);
    ss_i = 1'b0;
    idle(6);
    chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R4 clock and data released",
        {sck_oe, mosi_oe}, 0);
    rd(2'd0, d); chk(d[1:0] == 2'b00, "R4 master and enable cleared", d[1:0], 0);
    chk(irq == 1'b1, "R2 irq on fault", irq, 1);
    wr(2'd0, 8'h81);
    rd(2'd0, d); chk(d[0] == 1'b0, "R5 enable locked without status read", d[0], 0);
    rd(2'd2, d); chk(d[6] == 1'b1, "R5 fault flag visible", d, 8'h40);
    ss_i = 1'b1;
    idle(4);
    wr(2'd0, 8'h81);
    rd(2'd0, d); chk(d == 8'h80, "R5 recovery write leaves enable off", d, 8'h80);
    rd(2'd2, d); chk(d[6] == 1'b0, "R5 fault flag cleared", d, 8'h00);
    chk(irq == 1'b0, "R2 no irq after recovery", irq, 0);
    wr(2'd0, 8'h81);
    rd(2'd0, d); chk(d == 8'h81, "R5 enable settable after recovery", d, 8'h81);

    // R13: slave mode, cpol0 cpha0 msb-first
    wr(2'd0, 8'h00);
    ss_i = 1'b1;
    wr(2'd0, 8'h81);
    wr(2'd3, 8'hC9);
    for (int b = 0; b < 8; b++) begin
      idle(8); sck_i = 1'b1; idle(8); sck_i = 1'b0;
    end
    idle(8);
    rd(2'd2, d); chk(d[7] == 1'b0, "R13 edges ignored while deselected", d, 8'h00);
    chk(miso_oe == 1'b0, "R13 data out released while deselected", miso_oe, 0);
    ss_i = 1'b0;
    idle(6);
    got = 8'h00;
    for (int b = 0; b < 8; b++) begin
      mosi_i = 8'h6B >> (7 - b);
      idle(8);
      got = {got[6:0], miso_o};
      sck_i = 1'b1; idle(8); sck_i = 1'b0;
    end
    idle(8);
    ss_i = 1'b1;
    idle(4);
    chk(got == 8'hC9, "R13 slave sent byte", got, 8'hC9);
    chk(irq == 1'b1, "R13 done irq in slave", irq, 1);
    // R9: data access without a prior status read keeps the flag
    rd(2'd3, d); chk(d == 8'h6B, "R13 slave received byte", d, 8'h6B);
    rd(2'd2, d); chk(d[7] == 1'b1, "R9 flag kept without status read", d, 8'h80);
    rd(2'd3, d);
    rd(2'd2, d); chk(d[7] == 1'b0, "R9 flag cleared by sequence", d, 8'h00);

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule